// File: doc/BRIEF.md
# Split Next-Address Calculator for Variable-Length Fetch

This block works out the address of the next sequential instruction in a fetch stage where instructions are 1, 2, 5 or 6 bytes long. It takes the current program counter and two flags from the early decode. One flag says the instruction carries a register-specifier byte. The other says it carries a four-byte constant. The result comes out combinationally in the same cycle as its inputs.

The block is built so that the slow part of the addition starts before the length is known. The counter is cut into a narrow low field and a wide high field. As soon as the counter value is present, the high field is incremented by one. Only the narrow low field waits for the flags: it is added to the length, and that addition's carry-out picks either the incremented or the untouched high field. A register stage with a synchronised reset release also holds the result, so that the value can be observed cycle by cycle.

Top module: `fpc_next_pc`

## Requirements
- R1: The instruction length is 1 byte, plus 1 when `has_reg_i` is 1, plus 4 when `has_const_i` is 1. The flag pairs (reg,const) = (0,0), (1,0), (0,1) and (1,1) give lengths of 1, 2, 5 and 6.
- R2: Bits [2:0] of `next_pc_o` equal (`pc_i[2:0]` + length) mod 8.
- R3: Bits [31:3] of `next_pc_o` equal `pc_i[31:3]` + 1 (mod 2^29) when `pc_i[2:0]` + length is 8 or more. Otherwise they equal `pc_i[31:3]` unchanged.
- R4: `next_pc_o` equals `pc_i` + length modulo 2^32 for every input. This includes wraparound, for example 0xFFFFFFFF with length 6 gives 0x00000005.
- R5: `next_pc_o` is a combinational function of the present inputs and is valid in the same cycle as those inputs.
- R6: `next_pc_q_o` is 0 while `rst_n` is low. After the synchronised reset release it equals the value `next_pc_o` had at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register and the reset synchroniser |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pc_i | input | 32 | Current program counter |
| has_reg_i | input | 1 | Instruction carries a register-specifier byte |
| has_const_i | input | 1 | Instruction carries a four-byte constant |
| next_pc_o | output | 32 | Combinational next sequential address |
| next_pc_q_o | output | 32 | Registered copy of `next_pc_o` |

## Verification
On every cycle the assertions check the following. The full sum matches a plain addition. The high field stays put when the low field does not carry. The low field agrees with a narrow modulo sum. The registered output follows the combinational one by exactly one edge.

Only the bench scenarios can show certain things. One is that each flag pair and each low-field value has actually been driven. Another is that the wrap cases at the very top of the address space were reached. A third is that the register holds zero through the reset and the synchroniser's two-cycle release.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  localparam int unsigned REG_SPEC_BYTES = 1;
  localparam int unsigned CONST_BYTES    = 4;
  localparam int unsigned BASE_BYTES     = 1;
endpackage

// File: rtl/fpc_low_add.sv
module fpc_low_add #(
  parameter int unsigned LO_W = 3
) (
  input  logic [LO_W-1:0] lo_i,
  input  logic            has_reg_i,
  input  logic            has_const_i,
  output logic [LO_W-1:0] sum_o,
  output logic            carry_o
);
  import fpc_pkg::*;

  logic [LO_W-1:0] len;
  logic [LO_W:0]   wide_sum;

  // length from the two decode flags
  always_comb begin
    len = LO_W'(BASE_BYTES);
    if (has_reg_i)   len = len + LO_W'(REG_SPEC_BYTES);
    if (has_const_i) len = len + LO_W'(CONST_BYTES);
  end

  always_comb begin
    wide_sum = {1'b0, lo_i} + {1'b0, len};
    sum_o    = wide_sum[LO_W-1:0];
    carry_o  = wide_sum[LO_W];
  end
endmodule

// File: rtl/fpc_hi_inc.sv
module fpc_hi_inc #(
  parameter int unsigned HI_W = 29
) (
  input  logic [HI_W-1:0] hi_i,
  output logic [HI_W-1:0] inc_o
);
  // ripple of half adders, independent of the length flags
  logic [HI_W-1:0] c;
  assign c[0] = 1'b1;

  for (genvar g = 0; g < HI_W; g++) begin : g_bit
    assign inc_o[g] = hi_i[g] ^ c[g];
    if (g < HI_W - 1) begin : g_carry
      assign c[g+1] = hi_i[g] & c[g];
    end
  end
endmodule

// File: rtl/fpc_hi_sel.sv
module fpc_hi_sel #(
  parameter int unsigned HI_W = 29
) (
  input  logic [HI_W-1:0] hi_i,
  input  logic [HI_W-1:0] inc_i,
  input  logic            carry_i,
  output logic [HI_W-1:0] hi_o
);
  always_comb begin
    if (carry_i) hi_o = inc_i;
    else         hi_o = hi_i;
  end
endmodule

// File: rtl/fpc_next_pc.sv
module fpc_next_pc #(
  parameter int unsigned PC_W = 32,
  parameter int unsigned LO_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] pc_i,
  input  logic            has_reg_i,
  input  logic            has_const_i,
  output logic [PC_W-1:0] next_pc_o,
  output logic [PC_W-1:0] next_pc_q_o
);
  localparam int unsigned HI_W = PC_W - LO_W;

  logic [LO_W-1:0] lo_sum;
  logic            lo_carry;
  logic [HI_W-1:0] hi_inc;
  logic [HI_W-1:0] hi_sel;
  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  logic [PC_W-1:0] next_pc_d;

  fpc_low_add #(.LO_W(LO_W)) u_low (
    .lo_i        (pc_i[LO_W-1:0]),
    .has_reg_i   (has_reg_i),
    .has_const_i (has_const_i),
    .sum_o       (lo_sum),
    .carry_o     (lo_carry)
  );

  fpc_hi_inc #(.HI_W(HI_W)) u_inc (
    .hi_i  (pc_i[PC_W-1:LO_W]),
    .inc_o (hi_inc)
  );

  fpc_hi_sel #(.HI_W(HI_W)) u_sel (
    .hi_i    (pc_i[PC_W-1:LO_W]),
    .inc_i   (hi_inc),
    .carry_i (lo_carry),
    .hi_o    (hi_sel)
  );

  assign next_pc_o = {hi_sel, lo_sum};

  // reset: asserted asynchronously, released after two edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    next_pc_d = next_pc_o;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) next_pc_q_o <= '0;
    else            next_pc_q_o <= next_pc_d;
  end
endmodule

// File: rtl/fpc_next_pc_chk.sv
module fpc_next_pc_chk #(
  parameter int unsigned PC_W = 32,
  parameter int unsigned LO_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] pc_i,
  input logic            has_reg_i,
  input logic            has_const_i,
  input logic [PC_W-1:0] next_pc_o,
  input logic [PC_W-1:0] next_pc_q_o
);
  logic [PC_W-1:0] ref_len;
  logic [LO_W:0]   ref_lo;
  always_comb begin
    ref_len = PC_W'(1) + (has_reg_i ? PC_W'(1) : '0) + (has_const_i ? PC_W'(4) : '0);
    ref_lo  = {1'b0, pc_i[LO_W-1:0]} + (LO_W+1)'(ref_len);
  end

  // R4, R5: full sum in the same cycle
  a_r4_full_sum: assert property (@(posedge clk) disable iff (!rst_n)
    next_pc_o == pc_i + ref_len);

  // R2: low field
  a_r2_low_field: assert property (@(posedge clk) disable iff (!rst_n)
    next_pc_o[LO_W-1:0] == ref_lo[LO_W-1:0]);

  // R3: upper field held when no carry
  a_r3_hi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_lo[LO_W] |-> next_pc_o[PC_W-1:LO_W] == pc_i[PC_W-1:LO_W]);

  // R1: length never zero, so the address always moves
  a_r1_moves: assert property (@(posedge clk) disable iff (!rst_n)
    next_pc_o != pc_i);

  // R6: register follows by one edge
  a_r6_reg_follow: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) or 1'b1 |=> next_pc_q_o == $past(next_pc_o));
endmodule

bind fpc_next_pc fpc_next_pc_chk #(.PC_W(PC_W), .LO_W(LO_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_int_n),
  .pc_i        (pc_i),
  .has_reg_i   (has_reg_i),
  .has_const_i (has_const_i),
  .next_pc_o   (next_pc_o),
  .next_pc_q_o (next_pc_q_o)
);

// File: tb/tb_fpc_next_pc.sv
`timescale 1ns/1ps
module tb_fpc_next_pc;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] pc;
  logic        fr, fc;
  logic [31:0] nxt, nxt_q;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [31:0] exp_prev;

  always #2.5 clk = ~clk;

  fpc_next_pc dut (
    .clk(clk), .rst_n(rst_n), .pc_i(pc), .has_reg_i(fr), .has_const_i(fc),
    .next_pc_o(nxt), .next_pc_q_o(nxt_q)
  );

  function automatic longint ref_len(bit r, bit c);
    return 1 + (r ? 1 : 0) + (c ? 4 : 0);
  endfunction

  function automatic logic [31:0] ref_next(logic [31:0] p, bit r, bit c);
    longint s;
    s = longint'(p) + ref_len(r, c);
    return s[31:0];
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s pc=%h r=%0b c=%0b actual=%h expected=%h", req, pc, fr, fc, act, exp);
    end
  endtask

  // one cycle: check last registered value, drive, check combinational
  task automatic apply(logic [31:0] p, bit r, bit c, string req);
    @(negedge clk);
    check("R6 registered", nxt_q, exp_prev);
    pc = p; fr = r; fc = c;
    #1;
    check(req, nxt, ref_next(p, r, c));
    check("R2 low field", {29'd0, nxt[2:0]}, {29'd0, 3'((p[2:0] + 3'(ref_len(r, c))))});
    exp_prev = ref_next(p, r, c);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pc = '0; fr = 0; fc = 0;
    repeat (3) @(negedge clk);
    check("R6 reset", nxt_q, 32'd0);
    #1 check("R5 during reset", nxt, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R6 sync release holds zero", nxt_q, 32'd0);
    repeat (3) @(negedge clk);
    exp_prev = 32'd1;

    // R1: each flag pair from the same base
    apply(32'h0000_1000, 0, 0, "R1 len1");
    apply(32'h0000_1000, 1, 0, "R1 len2");
    apply(32'h0000_1000, 0, 1, "R1 len5");
    apply(32'h0000_1000, 1, 1, "R1 len6");
    // R3: carry into upper field, and no carry
    apply(32'h0000_1007, 0, 0, "R3 carry len1");
    apply(32'h0000_1002, 1, 1, "R3 carry len6");
    apply(32'h0000_1001, 1, 1, "R3 no carry");
    apply(32'h1234_5FFB, 0, 1, "R3 long carry ripple");
    // R4: wraparound
    apply(32'hFFFF_FFFF, 1, 1, "R4 wrap to 5");
    apply(32'hFFFF_FFFA, 1, 1, "R4 wrap to 0");
    apply(32'hFFFF_FFF8, 0, 0, "R4 top no wrap");
    apply(32'h7FFF_FFFF, 0, 0, "R4 sign boundary");
    // R2/R3: every low value with every flag pair
    for (int lo = 0; lo < 8; lo++)
      for (int f = 0; f < 4; f++)
        apply({29'h0ABC_DEF0, 3'(lo)}, f[0], f[1], "R3 sweep");
    // R4: random spread, back-to-back
    for (int i = 0; i < 300; i++)
      apply($urandom, 1'($urandom), 1'($urandom), "R4 random");
    @(negedge clk);
    check("R6 final registered", nxt_q, exp_prev);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule